// File: doc/BRIEF.md
# Peripheral Slot Address Decoder

This block sits between a system bus and a group of memory-mapped peripherals. The peripheral window starts at 0x4000_0000 and is cut into 64 slots of 4096 bytes each, so each slot holds 1024 words of 32 bits. The slot number is read directly from address bits [17:12]. A static parameter table assigns every peripheral to one slot. The decoder raises the select line of the one peripheral that owns the addressed slot and returns that peripheral's read data.

Several mutually exclusive peripherals may occupy one slot. The decoder uses their enable flags to pick which one is live. When none of them is enabled, the lowest-numbered one answers, so software can still configure it. Slot 0 is special: it may legally have several members enabled at once. On any other slot, two or more enabled members are a misuse, and the decoder records this in a sticky flag. Each slot also owns one interrupt vector bit, at the index equal to its slot number, and every peripheral's interrupt line is folded into that bit.

Top module: `periph_slot_decoder`

## Requirements
- R1: An access with `bus_req` high and `bus_addr[31:18]` equal to 0x4000_0000's upper bits decodes slot `bus_addr[17:12]`. Address bits [11:0] do not affect the decode. Default table: peripherals 0,1 in slot 0; 2,3 in slot 2; 4,5,6 in slot 5; 7 in slot 31.
- R2: `per_sel` has at most one bit set, and is all zero while `bus_req` is low.
- R3: On a slot whose members are all disabled, the lowest-numbered member is selected.
- R4: On a slot with exactly one enabled member, that member is selected, even if it is not the lowest-numbered member.
- R5: When several members of a slot are enabled, the lowest-numbered enabled member is selected.
- R6: `bus_rdata` equals the selected peripheral's `per_rdata` word (peripheral i uses bits [32i+31:32i]). It is zero when nothing is selected.
- R7: A requested access to an unpopulated slot, or to an address outside the window, selects nothing. `bus_err` is then high for the single cycle after the request edge. In every other case `bus_err` is low.
- R8: `slot_conflict` rises one clock after any nonzero slot has two or more enabled members. It stays high until reset. Multiple enabled members in slot 0 never set it.
- R9: `irq_vec[k]` is the OR of `per_irq` of every peripheral mapped to slot k. Bits of slots with no members are zero.
- R10: While `rst` is high, `bus_err` and `slot_conflict` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_req | input | 1 | Access strobe |
| per_en | input | NUM_PERIPH | Enable flag of each peripheral |
| per_irq | input | NUM_PERIPH | Interrupt line of each peripheral |
| per_rdata | input | NUM_PERIPH*32 | Read data of each peripheral, flattened |
| per_sel | output | NUM_PERIPH | Select of each peripheral |
| bus_rdata | output | 32 | Read data returned to the bus |
| bus_err | output | 1 | One-cycle error pulse for undecoded access |
| slot_conflict | output | 1 | Sticky flag: shared slot had several enables |
| irq_vec | output | 64 | Interrupt vector indexed by slot number |

## Verification
The hardest state to reach from the ports is a conflict on a nonzero shared slot that must coexist with an earlier, legal double enable on slot 0. If slot 0 came second, the sticky flag would mask its effect. The stimulus therefore enables both slot 0 members first and confirms the flag stays low. Only late in the run does it enable two members of the three-member slot, then check that the lowest enabled member is still selected and that the flag survives all enables dropping.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int OFFS_W   = 12;
    localparam int ID_W     = 6;
    localparam int NUM_SLOTS = 1 << ID_W;
    localparam int TAG_LSB  = OFFS_W + ID_W;
    localparam logic [ADDR_W-1:0] WINDOW_BASE = 32'h4000_0000;

    typedef logic [ID_W-1:0] slot_id_t;

    typedef struct packed {
        logic     in_window;
        slot_id_t id;
    } addr_dec_t;

    function automatic addr_dec_t split_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.in_window = (a[ADDR_W-1:TAG_LSB] == WINDOW_BASE[ADDR_W-1:TAG_LSB]);
        d.id        = a[TAG_LSB-1:OFFS_W];
        return d;
    endfunction
endpackage

// File: rtl/pid_member_pick.sv
module pid_member_pick
    import pid_pkg::*;
#(
    parameter int NP = 8,
    parameter logic [NP*ID_W-1:0] SLOT_MAP = '0
) (
    input  addr_dec_t       dec,
    input  logic            req,
    input  logic [NP-1:0]   en,
    output logic [NP-1:0]   sel
);
    logic [NP-1:0] member;
    logic [NP-1:0] pick;
    logic          got;

    always_comb begin
        for (int i = 0; i < NP; i++)
            member[i] = dec.in_window && (SLOT_MAP[i*ID_W +: ID_W] == dec.id);
        pick = '0;
        got  = 1'b0;
        // enabled members take precedence, lowest index first
        for (int i = 0; i < NP; i++)
            if (!got && member[i] && en[i]) begin
                pick[i] = 1'b1;
                got     = 1'b1;
            end
        // otherwise fall back to the lowest member so it can be configured
        for (int i = 0; i < NP; i++)
            if (!got && member[i]) begin
                pick[i] = 1'b1;
                got     = 1'b1;
            end
        sel = req ? pick : '0;
    end
endmodule

// File: rtl/pid_irq_fold.sv
module pid_irq_fold
    import pid_pkg::*;
#(
    parameter int NP = 8,
    parameter logic [NP*ID_W-1:0] SLOT_MAP = '0
) (
    input  logic [NP-1:0]        irq,
    output logic [NUM_SLOTS-1:0] vec
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_comb begin
            vec[s] = 1'b0;
            for (int i = 0; i < NP; i++)
                if (SLOT_MAP[i*ID_W +: ID_W] == ID_W'(s))
                    vec[s] = vec[s] | irq[i];
        end
    end
endmodule

// File: rtl/pid_conflict_mon.sv
module pid_conflict_mon
    import pid_pkg::*;
#(
    parameter int NP = 8,
    parameter logic [NP*ID_W-1:0] SLOT_MAP = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] en,
    output logic          conflict
);
    localparam int CNT_W = $clog2(NP + 1);

    logic [NUM_SLOTS-1:0] multi;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_free
            // slot 0 members may legitimately run together
            assign multi[s] = 1'b0;
        end else begin : g_chk
            logic [CNT_W-1:0] n;
            always_comb begin
                n = '0;
                for (int i = 0; i < NP; i++)
                    if (en[i] && (SLOT_MAP[i*ID_W +: ID_W] == ID_W'(s)))
                        n = n + 1'b1;
                multi[s] = (n > CNT_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            conflict <= 1'b0;
        else if (|multi)
            conflict <= 1'b1;
    end

    a_r8_conflict_sticky: assert property (@(posedge clk) disable iff (rst)
        conflict |=> conflict);
endmodule

// File: rtl/periph_slot_decoder.sv
module periph_slot_decoder
    import pid_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter logic [NUM_PERIPH*ID_W-1:0] SLOT_MAP =
        {6'd31, 6'd5, 6'd5, 6'd5, 6'd2, 6'd2, 6'd0, 6'd0}
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_req,
    input  logic [NUM_PERIPH-1:0]        per_en,
    input  logic [NUM_PERIPH-1:0]        per_irq,
    input  logic [NUM_PERIPH*DATA_W-1:0] per_rdata,
    output logic [NUM_PERIPH-1:0]        per_sel,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_err,
    output logic                         slot_conflict,
    output logic [NUM_SLOTS-1:0]         irq_vec
);
    addr_dec_t dec;
    assign dec = split_addr(bus_addr);

    pid_member_pick #(.NP(NUM_PERIPH), .SLOT_MAP(SLOT_MAP)) u_pick (
        .dec (dec),
        .req (bus_req),
        .en  (per_en),
        .sel (per_sel)
    );

    pid_irq_fold #(.NP(NUM_PERIPH), .SLOT_MAP(SLOT_MAP)) u_irq (
        .irq (per_irq),
        .vec (irq_vec)
    );

    pid_conflict_mon #(.NP(NUM_PERIPH), .SLOT_MAP(SLOT_MAP)) u_conf (
        .clk      (clk),
        .rst      (rst),
        .en       (per_en),
        .conflict (slot_conflict)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_PERIPH; i++)
            if (per_sel[i])
                bus_rdata = per_rdata[i*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_err <= 1'b0;
        else
            bus_err <= bus_req && (per_sel == '0);
    end

    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(per_sel) && (!bus_req -> per_sel == '0));

    a_r6_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        (per_sel == '0) |-> (bus_rdata == '0));

    a_r7_err_follows_miss: assert property (@(posedge clk) disable iff (rst)
        (bus_req && per_sel == '0) |=> bus_err);

    a_r7_no_err_on_hit: assert property (@(posedge clk) disable iff (rst)
        (!bus_req || per_sel != '0) |=> !bus_err);

    a_r9_quiet_irqs: assert property (@(posedge clk) disable iff (rst)
        (per_irq == '0) |-> (irq_vec == '0));
endmodule

// File: tb/sim_periph_slot_decoder.sv
`timescale 1ns/100ps
module sim_periph_slot_decoder;
    localparam int NP = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     bus_addr = '0;
    logic            bus_req = 1'b0;
    logic [NP-1:0]   per_en = '0;
    logic [NP-1:0]   per_irq = '0;
    logic [NP*32-1:0] per_rdata = '0;
    logic [NP-1:0]   per_sel;
    logic [31:0]     bus_rdata;
    logic            bus_err;
    logic            slot_conflict;
    logic [63:0]     irq_vec;

    int checks = 0;
    int errors = 0;
    int home [NP] = '{0, 0, 2, 2, 5, 5, 5, 31};

    logic m_err = 1'b0;
    logic m_conf = 1'b0;

    always #2.5 clk = ~clk;

    periph_slot_decoder u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_req(bus_req),
        .per_en(per_en), .per_irq(per_irq), .per_rdata(per_rdata),
        .per_sel(per_sel), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .slot_conflict(slot_conflict), .irq_vec(irq_vec)
    );

    function automatic logic [NP-1:0] want_sel(logic [31:0] a, logic rq, logic [NP-1:0] en);
        logic [NP-1:0] r = '0;
        int slot;
        if (!rq || (a >> 18) != (32'h4000_0000 >> 18)) return r;
        slot = int'((a >> 12) & 32'h3F);
        for (int i = 0; i < NP; i++)
            if (home[i] == slot && en[i]) begin r[i] = 1'b1; return r; end
        for (int i = 0; i < NP; i++)
            if (home[i] == slot) begin r[i] = 1'b1; return r; end
        return r;
    endfunction

    function automatic logic want_conf(logic [NP-1:0] en);
        for (int s = 1; s < 64; s++) begin
            int n = 0;
            for (int i = 0; i < NP; i++)
                if (home[i] == s && en[i]) n++;
            if (n > 1) return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_err  <= 1'b0;
            m_conf <= 1'b0;
        end else begin
            m_err  <= bus_req && (want_sel(bus_addr, bus_req, per_en) == '0);
            m_conf <= m_conf | want_conf(per_en);
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic [31:0] a, input logic rq,
                        input logic [NP-1:0] en, input logic [NP-1:0] irq, input logic [31:0] seed);
        logic [NP-1:0] es;
        logic [31:0]   er;
        logic [63:0]   ev;
        @(negedge clk);
        chk(bus_err == m_err, "R7 err", 64'(bus_err), 64'(m_err));
        chk(slot_conflict == m_conf, "R8 conflict", 64'(slot_conflict), 64'(m_conf));
        bus_addr = a; bus_req = rq; per_en = en; per_irq = irq;
        for (int i = 0; i < NP; i++)
            per_rdata[i*32 +: 32] = (32'(i + 1) * 32'h0101_0101) ^ seed;
        #1;
        es = want_sel(a, rq, en);
        er = '0;
        for (int i = 0; i < NP; i++) if (es[i]) er = per_rdata[i*32 +: 32];
        ev = '0;
        for (int i = 0; i < NP; i++) if (irq[i]) ev[home[i]] = 1'b1;
        chk(per_sel == es, tag, 64'(per_sel), 64'(es));
        chk($countones(per_sel) <= 1, "R2 onehot", 64'(per_sel), 64'(es));
        chk(bus_rdata == er, "R6 rdata", 64'(bus_rdata), 64'(er));
        chk(irq_vec == ev, "R9 irq", irq_vec, ev);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bus_req = 1'b1; bus_addr = 32'h4000_3000;
        repeat (3) @(negedge clk);
        chk(bus_err == 1'b0, "R10 reset err", 64'(bus_err), 64'd0);
        chk(slot_conflict == 1'b0, "R10 reset conflict", 64'(slot_conflict), 64'd0);
        rst = 1'b0; bus_req = 1'b0;

        step("R3 slot0 none enabled",  32'h4000_0010, 1, 8'h00, 8'h00, 32'h1);
        step("R5 slot0 both enabled",  32'h4000_0FFC, 1, 8'h03, 8'h02, 32'h2);
        step("R1 slot31 top offset",   32'h4001_FFFC, 1, 8'h03, 8'h80, 32'h3);
        step("R3 slot2 none enabled",  32'h4000_2000, 1, 8'h00, 8'h0C, 32'h4);
        step("R4 slot2 upper enabled", 32'h4000_2404, 1, 8'h08, 8'h10, 32'h5);
        step("R4 slot5 last enabled",  32'h4000_5008, 1, 8'h40, 8'h60, 32'h6);
        step("R3 slot5 none enabled",  32'h4000_5000, 1, 8'h00, 8'hFF, 32'h7);
        step("R7 unpopulated slot3",   32'h4000_3000, 1, 8'h00, 8'h00, 32'h8);
        step("R7 unpopulated slot63",  32'h4003_F000, 1, 8'h01, 8'h01, 32'h9);
        step("R7 above window",        32'h4004_0000, 1, 8'h00, 8'h00, 32'hA);
        step("R7 below window",        32'h3FFF_F000, 1, 8'h00, 8'h00, 32'hB);
        step("R2 no request",          32'h4000_2000, 0, 8'h04, 8'h00, 32'hC);
        step("R1 slot31 base",         32'h4001_F000, 1, 8'h80, 8'h00, 32'hD);
        step("R5 slot5 two enabled",   32'h4000_5000, 1, 8'h60, 8'h20, 32'hE);
        step("R5 slot2 both enabled",  32'h4000_2000, 1, 8'h0C, 8'h00, 32'hF);
        step("R8 sticky after clear",  32'h4000_2000, 1, 8'h00, 8'h00, 32'h10);
        step("R8 idle",                32'h0000_0000, 0, 8'h00, 8'h00, 32'h11);
        step("R8 idle",                32'h0000_0000, 0, 8'h00, 8'h00, 32'h12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule